// File: doc/BRIEF.md
# Guarded PLL Configuration Register File

This block holds the divider and spread-spectrum settings that a PLL consumes. Software writes them through a simple one-cycle write port and reads them back through a combinational read port. A companion guard word carries one protection bit per guarded setting. A guard bit stops software from changing its setting, but only while the live PLL status says a change would be unsafe. Every stored setting is driven out continuously to the analog PLL.

Five settings are guarded: the reference divider, the post divider, the spread depth, the spread divide value and the spread reset pointer. Each guard bit sits in the guard word at the position of the lowest bit of the setting it protects. The first four settings are protected while the guard bit is set and the PLL is powered up. The reset pointer is protected under the same conditions, and it is also released while the PLL reports lock. The integer/fractional mode bit and the spread-direction bit are never guarded.

The live status is read by a three-state guard machine, registered once per clock. Its states are OPEN (PLL powered down), GUARD_ALL (powered up, not locked) and GUARD_PTR_FREE (powered up and locked). The transitions are: any state goes to OPEN when power-down is high. With power-down low, any state goes to GUARD_ALL when lock is low and to GUARD_PTR_FREE when lock is high. The machine leaves reset in GUARD_ALL. A write is judged against the state held before its clock edge.

Top module: `pllcfg_regs`

## Requirements
- R1: After reset every setting, every guard bit, rd_data at both register offsets and every field output are zero.
- R2: The guard word (offset 1) accepts every write in every PLL state and reads back with guard bits only at positions 31, 24, 20, 14 and 8. All other bits read zero.
- R3: A guarded setting whose guard bit is 0 takes the written value on every configuration write (offset 0), whatever the PLL status.
- R4: Reference divider (bits 29:24), post divider (22:20), spread depth (18:14) and spread divide (13:8) keep their value when written while their guard bit is 1 and power-down is low. They update when power-down is high.
- R5: The spread reset pointer (bit 31) is protected only when its guard bit is 1, power-down is low and lock is low. With lock high, it updates even with its guard bit set.
- R6: A blocked setting is silently ignored, while the other settings in the same configuration write still update.
- R7: The mode bit (bit 3, 1 = integer, 0 = fractional) and the spread-direction bit (bit 7, 0 = center, 1 = down) are never guarded. Configuration readback returns zero in all bits that hold no setting.
- R8: The protection applied to a write uses the power-down and lock values sampled at the clock edge before the write edge, through the states OPEN, GUARD_ALL and GUARD_PTR_FREE.
- R9: The field outputs always equal the stored settings. Offsets other than 0 and 1 read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wr_addr | input | ADDR_W | Write word offset |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Read word offset |
| rd_data | output | 32 | Combinational read data |
| ana_pd | input | 1 | PLL power-down status, 1 = powered down |
| pll_locked | input | 1 | Combined PLL lock status |
| refdiv_o | output | 6 | Reference divider setting |
| postdiv_o | output | 3 | Post divider setting |
| spread_depth_o | output | 5 | Spread depth setting |
| spread_div_o | output | 6 | Spread divide setting |
| spread_rstptr_o | output | 1 | Spread reset pointer |
| down_spread_o | output | 1 | Spread direction, 1 = down spread |
| int_mode_o | output | 1 | 1 = integer mode, 0 = fractional mode |

## Verification
The bench builds the block with its default parameters: a 2-bit offset with the configuration word at 0 and the guard word at 1. This leaves offsets 2 and 3 free for the unused-address cases. With that small configuration, the bench sweeps every one of the 32 guard patterns against all four combinations of power-down and lock. Each setting's expected value is computed from whether that guard, power and lock combination protects it. Separate sequences change the status on the same edge as a write, to reach the one-cycle sampling rule in both directions.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

    localparam int DATA_W      = 32;
    localparam int NUM_GUARDED = 5;
    localparam int PTR_IDX     = 4;
    localparam int INT_BIT     = 3;
    localparam int DOWN_BIT    = 7;

    typedef enum logic [1:0] {
        GS_OPEN        = 2'd0,
        GS_GUARD_ALL   = 2'd1,
        GS_GUARD_PTR_FREE = 2'd2
    } guard_state_e;

    // Lowest bit of each guarded setting; the guard bit shares this position.
    function automatic int fld_lsb(input int idx);
        case (idx)
            0:       return 24;
            1:       return 20;
            2:       return 14;
            3:       return 8;
            4:       return 31;
            default: return 0;
        endcase
    endfunction

    function automatic int fld_w(input int idx);
        case (idx)
            0:       return 6;
            1:       return 3;
            2:       return 5;
            3:       return 6;
            4:       return 1;
            default: return 1;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] make_lock_mask();
        logic [DATA_W-1:0] m;
        m = '0;
        for (int i = 0; i < NUM_GUARDED; i++) m[fld_lsb(i)] = 1'b1;
        return m;
    endfunction

    localparam logic [DATA_W-1:0] LOCK_MASK = make_lock_mask();

endpackage

// File: rtl/pllcfg_guard_fsm.sv
module pllcfg_guard_fsm
    import pllcfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ana_pd,
    input  logic pll_locked,
    output logic guard_on,
    output logic ptr_free
);

    guard_state_e state, state_nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GS_GUARD_ALL;
        else        state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            GS_OPEN: begin
                if (!ana_pd) state_nxt = pll_locked ? GS_GUARD_PTR_FREE : GS_GUARD_ALL;
            end
            GS_GUARD_ALL: begin
                if (ana_pd)          state_nxt = GS_OPEN;
                else if (pll_locked) state_nxt = GS_GUARD_PTR_FREE;
            end
            GS_GUARD_PTR_FREE: begin
                if (ana_pd)           state_nxt = GS_OPEN;
                else if (!pll_locked) state_nxt = GS_GUARD_ALL;
            end
            default: state_nxt = GS_GUARD_ALL;
        endcase
    end

    always_comb begin
        guard_on = 1'b1;
        ptr_free = 1'b0;
        unique case (state)
            GS_OPEN:           begin guard_on = 1'b0; ptr_free = 1'b0; end
            GS_GUARD_ALL:      begin guard_on = 1'b1; ptr_free = 1'b0; end
            GS_GUARD_PTR_FREE: begin guard_on = 1'b1; ptr_free = 1'b1; end
            default:           begin guard_on = 1'b1; ptr_free = 1'b0; end
        endcase
    end

    // R8: power-down seen at an edge opens all settings for the next write
    a_r8_pd_opens: assert property (@(posedge clk) disable iff (!rst_n)
        ana_pd |=> (state == GS_OPEN));
    // R8: powered and locked releases only the reset pointer
    a_r8_lock_frees_ptr: assert property (@(posedge clk) disable iff (!rst_n)
        (!ana_pd && pll_locked) |=> (state == GS_GUARD_PTR_FREE));
    // R8: powered and unlocked guards everything
    a_r8_unlocked_guards: assert property (@(posedge clk) disable iff (!rst_n)
        (!ana_pd && !pll_locked) |=> (state == GS_GUARD_ALL));

endmodule

// File: rtl/pllcfg_field.sv
module pllcfg_field #(
    parameter int W        = 6,
    parameter bit PTR_RULE = 1'b0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_stb,
    input  logic [W-1:0] wr_val,
    input  logic         lock_bit,
    input  logic         guard_on,
    input  logic         ptr_free,
    output logic [W-1:0] q
);

    logic blocked;

    always_comb begin
        blocked = lock_bit && guard_on;
        if (PTR_RULE && ptr_free) blocked = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  q <= '0;
        else if (wr_stb && !blocked) q <= wr_val;
    end

    // R4/R6: a protected setting ignores the write
    a_r4_blocked_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && blocked) |=> $stable(q));
    // R3: an unguarded setting always takes the write
    a_r3_open_takes: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !lock_bit) |=> (q == $past(wr_val)));

    if (PTR_RULE) begin : g_ptr_chk
        // R5: the reset pointer is released while locked
        a_r5_ptr_released: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_stb && ptr_free) |=> (q == $past(wr_val)));
    end

endmodule

// File: rtl/pllcfg_readmux.sv
module pllcfg_readmux #(
    parameter int ADDR_W   = 2,
    parameter int CFG_OFS  = 0,
    parameter int LOCK_OFS = 1
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [31:0]       cfg_word,
    input  logic [31:0]       lock_word,
    output logic [31:0]       rd_data
);

    localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_OFS);
    localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_OFS);

    always_comb begin
        if (rd_addr == CFG_A)       rd_data = cfg_word;
        else if (rd_addr == LOCK_A) rd_data = lock_word;
        else                        rd_data = '0;
    end

endmodule

// File: rtl/pllcfg_regs.sv
module pllcfg_regs
    import pllcfg_pkg::*;
#(
    parameter int ADDR_W   = 2,
    parameter int CFG_OFS  = 0,
    parameter int LOCK_OFS = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic              ana_pd,
    input  logic              pll_locked,
    output logic [5:0]        refdiv_o,
    output logic [2:0]        postdiv_o,
    output logic [4:0]        spread_depth_o,
    output logic [5:0]        spread_div_o,
    output logic              spread_rstptr_o,
    output logic              down_spread_o,
    output logic              int_mode_o
);

    localparam logic [ADDR_W-1:0] CFG_A  = ADDR_W'(CFG_OFS);
    localparam logic [ADDR_W-1:0] LOCK_A = ADDR_W'(LOCK_OFS);

    logic              cfg_wr, lock_wr;
    logic              guard_on, ptr_free;
    logic [DATA_W-1:0] lock_q;
    logic              int_mode_q, down_q;
    logic [DATA_W-1:0] fld_word [NUM_GUARDED];
    logic [DATA_W-1:0] cfg_word;
    logic              unused_wr_bits;

    assign cfg_wr         = wr_en && (wr_addr == CFG_A);
    assign lock_wr        = wr_en && (wr_addr == LOCK_A);
    assign unused_wr_bits = ^wr_data;

    pllcfg_guard_fsm u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .ana_pd     (ana_pd),
        .pll_locked (pll_locked),
        .guard_on   (guard_on),
        .ptr_free   (ptr_free)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lock_q <= '0;
        else if (lock_wr) lock_q <= wr_data & LOCK_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_mode_q <= 1'b0;
            down_q     <= 1'b0;
        end else if (cfg_wr) begin
            int_mode_q <= wr_data[INT_BIT];
            down_q     <= wr_data[DOWN_BIT];
        end
    end

    for (genvar gi = 0; gi < NUM_GUARDED; gi++) begin : g_fld
        localparam int LSB = fld_lsb(gi);
        localparam int W   = fld_w(gi);
        logic [W-1:0] q;

        pllcfg_field #(
            .W        (W),
            .PTR_RULE (gi == PTR_IDX)
        ) u_fld (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_stb   (cfg_wr),
            .wr_val   (wr_data[LSB +: W]),
            .lock_bit (lock_q[LSB]),
            .guard_on (guard_on),
            .ptr_free (ptr_free),
            .q        (q)
        );

        assign fld_word[gi] = {{(DATA_W-W){1'b0}}, q} << LSB;
    end

    always_comb begin
        cfg_word = '0;
        for (int i = 0; i < NUM_GUARDED; i++) cfg_word = cfg_word | fld_word[i];
        cfg_word[INT_BIT]  = int_mode_q;
        cfg_word[DOWN_BIT] = down_q;
    end

    pllcfg_readmux #(
        .ADDR_W   (ADDR_W),
        .CFG_OFS  (CFG_OFS),
        .LOCK_OFS (LOCK_OFS)
    ) u_rd (
        .rd_addr   (rd_addr),
        .cfg_word  (cfg_word),
        .lock_word (lock_q),
        .rd_data   (rd_data)
    );

    assign refdiv_o        = cfg_word[fld_lsb(0) +: 6];
    assign postdiv_o       = cfg_word[fld_lsb(1) +: 3];
    assign spread_depth_o  = cfg_word[fld_lsb(2) +: 5];
    assign spread_div_o    = cfg_word[fld_lsb(3) +: 6];
    assign spread_rstptr_o = cfg_word[fld_lsb(4)];
    assign down_spread_o   = down_q;
    assign int_mode_o      = int_mode_q;

    // R2: the guard word takes every write, keeping only guard positions
    a_r2_lock_always_wr: assert property (@(posedge clk) disable iff (!rst_n)
        lock_wr |=> (lock_q == ($past(wr_data) & LOCK_MASK)));
    // R7: mode bits follow every configuration write
    a_r7_mode_free: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> (int_mode_o == $past(wr_data[INT_BIT]) &&
                    down_spread_o == $past(wr_data[DOWN_BIT])));
    // R9: writes to other offsets leave all state untouched
    a_r9_unused_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !cfg_wr && !lock_wr) |=> ($stable(cfg_word) && $stable(lock_q)));

endmodule

// File: tb/pllcfg_regs_tb_top.sv
module pllcfg_regs_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] CFG_MASK = 32'hBF77_FF88;
    localparam logic [31:0] LK_MASK  = 32'h8110_4100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic        ana_pd = 1'b1;
    logic        pll_locked = 1'b0;
    logic [5:0]  refdiv_o;
    logic [2:0]  postdiv_o;
    logic [4:0]  spread_depth_o;
    logic [5:0]  spread_div_o;
    logic        spread_rstptr_o, down_spread_o, int_mode_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] fmask [5];
    int          flsb  [5];

    always #(CLK_PERIOD/2) clk = ~clk;

    pllcfg_regs dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ana_pd(ana_pd), .pll_locked(pll_locked),
        .refdiv_o(refdiv_o), .postdiv_o(postdiv_o),
        .spread_depth_o(spread_depth_o), .spread_div_o(spread_div_o),
        .spread_rstptr_o(spread_rstptr_o), .down_spread_o(down_spread_o),
        .int_mode_o(int_mode_o)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic do_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    function automatic logic [31:0] rd(input logic [1:0] a);
        return 32'(a);
    endfunction

    task automatic read_word(input logic [1:0] a, output logic [31:0] v);
        rd_addr = a;
        #1;
        v = rd_data;
    endtask

    function automatic logic [31:0] out_image(input logic [31:0] e);
        return {9'd0, e[31], e[29:24], e[22:20], e[18:14], e[13:8], e[7], e[3]};
    endfunction

    task automatic chk_outputs(input string tag, input logic [31:0] e);
        chk(tag, {9'd0, spread_rstptr_o, refdiv_o, postdiv_o, spread_depth_o,
                  spread_div_o, down_spread_o, int_mode_o}, out_image(e));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired got 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v, a_val, b_val, lw, exp;
        bit          prot;
        fmask[0] = 32'h3F00_0000; flsb[0] = 24;
        fmask[1] = 32'h0070_0000; flsb[1] = 20;
        fmask[2] = 32'h0007_C000; flsb[2] = 14;
        fmask[3] = 32'h0000_3F00; flsb[3] = 8;
        fmask[4] = 32'h8000_0000; flsb[4] = 31;

        // R1: reset state
        #(CLK_PERIOD*3);
        read_word(2'd0, v); chk("R1 cfg reset", v, 32'h0);
        read_word(2'd1, v); chk("R1 lock reset", v, 32'h0);
        chk_outputs("R1 outputs reset", 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // Sweep: 32 guard patterns x power-down x lock
        for (int c = 0; c < 128; c++) begin
            a_val = 32'h9E37_79B9 * (c + 1);
            b_val = ~a_val;
            lw = '0;
            for (int i = 0; i < 5; i++) if (c[i]) lw[flsb[i]] = 1'b1;

            do_write(2'd1, 32'h0);
            read_word(2'd1, v); chk("R2 guard clear in any state", v, 32'h0);
            ana_pd = 1'b1;
            do_write(2'd0, a_val);
            do_write(2'd1, lw | ~LK_MASK);
            read_word(2'd1, v); chk("R2 guard readback", v, lw);
            ana_pd = c[5]; pll_locked = c[6];
            do_write(2'd0, b_val);

            read_word(2'd0, v);
            exp = b_val & 32'h0000_0088;
            for (int i = 0; i < 5; i++) begin
                prot = lw[flsb[i]] && !ana_pd && !(i == 4 && pll_locked);
                exp = exp | ((prot ? a_val : b_val) & fmask[i]);
                if (i == 4)
                    chk(prot ? "R5 ptr held" : "R5 ptr written", v & fmask[i], exp & fmask[i]);
                else if (!lw[flsb[i]])
                    chk("R3 unguarded field written", v & fmask[i], exp & fmask[i]);
                else
                    chk(prot ? "R4 guarded field held" : "R4 field written while powered down",
                        v & fmask[i], exp & fmask[i]);
            end
            chk("R7 mode bits written", v & 32'h0000_0088, b_val & 32'h0000_0088);
            chk("R7 unused cfg bits zero", v & ~CFG_MASK, 32'h0);
            chk("R6 whole word mixes held and written", v, exp);
            chk_outputs("R9 outputs track storage", exp);
        end

        // R9: unused offsets
        read_word(2'd0, exp);
        read_word(2'd1, lw);
        do_write(2'd2, 32'hFFFF_FFFF);
        do_write(2'd3, 32'hFFFF_FFFF);
        read_word(2'd2, v); chk("R9 offset 2 reads zero", v, 32'h0);
        read_word(2'd3, v); chk("R9 offset 3 reads zero", v, 32'h0);
        read_word(2'd0, v); chk("R9 cfg unchanged by unused write", v, exp);
        read_word(2'd1, v); chk("R9 guard unchanged by unused write", v, lw);

        // R8: status sampled one edge before the write
        ana_pd = 1'b1; pll_locked = 1'b0;
        do_write(2'd1, 32'h0100_0000);
        do_write(2'd0, 32'h0500_0000);
        ana_pd = 1'b0;
        @(negedge clk);
        ana_pd = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h2A00_0000;
        @(negedge clk); wr_en = 1'b0;
        chk("R8 write on power-down edge still guarded", {26'd0, refdiv_o}, 32'h05);
        do_write(2'd0, 32'h2A00_0000);
        chk("R8 write after power-down sampled", {26'd0, refdiv_o}, 32'h2A);
        @(negedge clk);
        ana_pd = 1'b0; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 32'h1100_0000;
        @(negedge clk); wr_en = 1'b0;
        chk("R8 write on power-up edge still open", {26'd0, refdiv_o}, 32'h11);
        do_write(2'd0, 32'h3F00_0000);
        chk("R4 write after power-up sampled is held", {26'd0, refdiv_o}, 32'h11);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule